// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block handles power management for a small 8-bit microcontroller core. It holds an 8-bit power control register. Software writes that register to put the core into idle or power-down. In idle, the CPU clock enable drops and the oscillator keeps running. In power-down, the oscillator enable drops as well. While the core sleeps, the block watches the interrupt sources and the interrupt enable byte, and decides when the core wakes.

A policy bit in the register sets where execution resumes after a wake:
- With the policy bit clear, only an enabled interrupt ends the sleep. The block then raises a one-cycle vector request that carries the index of the winning source.
- With the policy bit set, any relevant raised flag ends the sleep, even when interrupts are masked. The block then raises a one-cycle resume strobe, and the core continues at the next instruction.

Power-down listens to fewer sources than idle. A power-down wake first restarts the oscillator. The core clock comes back only after a parameterized settling count has expired.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the CPU clock enable and the oscillator enable are both 1, and no vector request or resume strobe is active.
- R2: While the core runs, a write stores the byte, except that bit 4 always reads 0. The layout is:
  - bit 7: baud doubler
  - bit 6: hard power-down
  - bit 5: wake policy
  - bits 3 and 2: general-purpose flags
  - bit 1: power-down
  - bit 0: idle

  A write made while the core sleeps or is waking is ignored.
- R3: A write with bit 0 set (and bit 1 clear) enters idle. From the next cycle the CPU clock enable is 0 and the oscillator enable stays 1.
- R4: A write with bit 1 set enters power-down. From the next cycle both enables are 0. When bits 0 and 1 are both set, power-down wins.
- R5: With the policy bit at 0, the core wakes when some pending source has both its enable bit and the global enable set.
  - The enable byte maps bit k to source k, and bit 7 is the global enable.
  - The wake shows one cycle after the condition is sampled, as a one-cycle vector request. In that cycle the CPU clock enable is 1.
  - The vector index is the lowest-numbered pending, enabled source.
- R6: With the policy bit at 0, pending sources that are not enabled never end the sleep. The same holds when the global enable is clear.
- R7: With the policy bit at 1, any relevant pending source wakes the core, whatever the enable byte holds. The wake is a one-cycle resume strobe with vector index 0 and no vector request.
- R8: Source numbering is:
  - 0: external 0
  - 1: timer 0
  - 2: external 1
  - 3: timer 1
  - 4: serial
  - 5: timer 2

  Idle wakes on any of the six. Power-down wakes only on sources 0 to 3.
- R9: External sources 0 and 1 request wake-up while their pin is held low. This is level-sensitive, not edge-triggered.
- R10: On a power-down wake, the oscillator enable returns to 1 one cycle after the condition is sampled. The wake pulse follows STAB_CYC cycles later, and the CPU clock enable stays 0 until that pulse.
- R11: The wake clears register bits 0 and 1 in the pulse cycle and leaves the other bits unchanged.
- R12: Asserting reset during idle or power-down returns the block to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register contents |
| ext_int_ni | input | 2 | External interrupt pins 0 and 1, active low |
| tmr_flag_i | input | 2 | Timer 0 and timer 1 interrupt flags |
| ser_flag_i | input | 1 | Serial interrupt flag |
| tmr2_flag_i | input | 1 | Timer 2 interrupt flag |
| irq_en_i | input | 8 | Interrupt enable byte, bit 7 global |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| vec_req_o | output | 1 | One-cycle request to take an interrupt vector |
| vec_id_o | output | 3 | Source index for the vector request |
| resume_o | output | 1 | One-cycle strobe to resume at the next instruction |

## Verification
A wrong sleep state shows up on the clock enables in the cycle after the mode write. A lost or wrong wake decision shows up as a pulse that is missing, doubled, of the wrong kind, or early.
- In idle, a fault is visible exactly one cycle after the flag is driven.
- In power-down, a settling counter that is off by one moves the pulse away from the cycle that lies STAB_CYC cycles after the oscillator enable rises.

A mode bit that is not cleared appears on the register read port in the pulse cycle.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PDOWN, S_WARM, S_WAKE} pwc_state_e;

  localparam int unsigned BIT_IDL  = 0;
  localparam int unsigned BIT_PD   = 1;
  localparam int unsigned BIT_RSV  = 4;
  localparam int unsigned BIT_POL  = 5;
  localparam int unsigned IE_GLOB  = 7;
  localparam int unsigned NUM_SRC  = 6;
  localparam int unsigned ID_W     = $clog2(NUM_SRC);
  // sources able to end power-down: ext0, tmr0, ext1, tmr1
  localparam logic [NUM_SRC-1:0] PD_SRC_MASK = 6'b001111;
endpackage

// File: rtl/pwc_ctrl_reg.sv
module pwc_ctrl_reg
  import pwc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_mode_i,
  output logic [7:0] q_o
);
  logic [7:0] q;
  localparam logic [7:0] WR_MASK = ~(8'h01 << BIT_RSV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (wr_en_i) q <= wdata_i & WR_MASK;
    else if (clr_mode_i) begin
      q[BIT_IDL] <= 1'b0;
      q[BIT_PD]  <= 1'b0;
    end
  end

  assign q_o = q;

  p_mode_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_mode_i |=> (q_o[BIT_IDL] == 1'b0) && (q_o[BIT_PD] == 1'b0));
  p_keep_flags_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_mode_i |=> q_o[7:2] == $past(q_o[7:2]));
endmodule

// File: rtl/pwc_wake_eval.sv
module pwc_wake_eval
  import pwc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [7:0]         ie_i,
  input  logic               policy_i,
  input  logic               pd_mode_i,
  output logic               wake_o,
  output logic               vector_o,
  output logic [ID_W-1:0]    vec_id_o
);
  logic [NUM_SRC-1:0] relevant, enabled;
  logic unused_ie;
  assign unused_ie = ie_i[6];

  assign relevant = pd_mode_i ? (src_i & PD_SRC_MASK) : src_i;
  assign enabled  = relevant & ie_i[NUM_SRC-1:0] & {NUM_SRC{ie_i[IE_GLOB]}};
  assign wake_o   = policy_i ? |relevant : |enabled;
  assign vector_o = !policy_i;

  // lowest index wins
  always_comb begin
    vec_id_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (enabled[i]) vec_id_o = ID_W'(i);
    end
  end

  p_masked_no_vector_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && vector_o) |-> ie_i[IE_GLOB]);
  p_pd_sources_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_mode_i && wake_o) |-> |(src_i & PD_SRC_MASK));
endmodule

// File: rtl/pwc_fsm.sv
module pwc_fsm
  import pwc_pkg::*;
#(
  parameter int unsigned STAB_CYC = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_idl_i,
  input  logic            wr_pd_i,
  input  logic            wake_i,
  input  logic            vector_i,
  input  logic [ID_W-1:0] vec_id_i,
  output logic            run_o,
  output logic            pd_mode_o,
  output logic            clr_mode_o,
  output logic            cpu_clk_en_o,
  output logic            osc_en_o,
  output logic            vec_req_o,
  output logic            resume_o,
  output logic [ID_W-1:0] vec_id_o
);
  localparam int unsigned CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(STAB_CYC - 1);

  pwc_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q;
  logic            kind_q;
  logic [ID_W-1:0] id_q;
  logic            detect;

  assign detect = ((state_q == S_IDLE) || (state_q == S_PDOWN)) && wake_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RUN:   if (wr_en_i && wr_pd_i) state_d = S_PDOWN;
               else if (wr_en_i && wr_idl_i) state_d = S_IDLE;
      S_IDLE:  if (wake_i) state_d = S_WAKE;
      S_PDOWN: if (wake_i) state_d = S_WARM;
      S_WARM:  if (cnt_q == '0) state_d = S_WAKE;
      S_WAKE:  state_d = S_RUN;
      default: state_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_RUN;
      cnt_q   <= '0;
      kind_q  <= 1'b0;
      id_q    <= '0;
    end else begin
      state_q <= state_d;
      if (detect) begin
        kind_q <= vector_i;
        id_q   <= vector_i ? vec_id_i : '0;
      end
      if (state_q == S_PDOWN) cnt_q <= CNT_LOAD;
      else if (state_q == S_WARM && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign run_o        = (state_q == S_RUN);
  assign pd_mode_o    = (state_q == S_PDOWN);
  assign clr_mode_o   = (state_d == S_WAKE);
  assign cpu_clk_en_o = (state_q == S_RUN) || (state_q == S_WAKE);
  assign osc_en_o     = (state_q != S_PDOWN);
  assign vec_req_o    = (state_q == S_WAKE) && kind_q;
  assign resume_o     = (state_q == S_WAKE) && !kind_q;
  assign vec_id_o     = vec_req_o ? id_q : '0;

  p_pulse_clk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o || resume_o) |-> cpu_clk_en_o);
  p_single_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o || resume_o) |=> !(vec_req_o || resume_o));
  p_one_kind_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vec_req_o, resume_o}));
  p_osc_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !cpu_clk_en_o);
  p_no_direct_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !(vec_req_o || resume_o));
  p_enter_pd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && wr_en_i && wr_pd_i) |=> (!osc_en_o && !cpu_clk_en_o));
  p_enter_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && wr_en_i && wr_idl_i && !wr_pd_i) |=> (osc_en_o && !cpu_clk_en_o));
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned STAB_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic [1:0] ext_int_ni,
  input  logic [1:0] tmr_flag_i,
  input  logic       ser_flag_i,
  input  logic       tmr2_flag_i,
  input  logic [7:0] irq_en_i,
  output logic       cpu_clk_en_o,
  output logic       osc_en_o,
  output logic       vec_req_o,
  output logic [2:0] vec_id_o,
  output logic       resume_o
);
  logic [7:0]         ctrl_q;
  logic [NUM_SRC-1:0] src;
  logic               run, pd_mode, clr_mode, wake, vector, wr_ok;
  logic [ID_W-1:0]    eval_id, out_id;

  // source order: ext0, tmr0, ext1, tmr1, serial, tmr2
  assign src   = {tmr2_flag_i, ser_flag_i, tmr_flag_i[1], ~ext_int_ni[1],
                  tmr_flag_i[0], ~ext_int_ni[0]};
  assign wr_ok = reg_we_i && run;

  pwc_ctrl_reg i_reg (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_ok),
    .wdata_i   (reg_wdata_i),
    .clr_mode_i(clr_mode),
    .q_o       (ctrl_q)
  );

  pwc_wake_eval i_eval (
    .clk_i, .rst_ni,
    .src_i    (src),
    .ie_i     (irq_en_i),
    .policy_i (ctrl_q[BIT_POL]),
    .pd_mode_i(pd_mode),
    .wake_o   (wake),
    .vector_o (vector),
    .vec_id_o (eval_id)
  );

  pwc_fsm #(.STAB_CYC(STAB_CYC)) i_fsm (
    .clk_i, .rst_ni,
    .wr_en_i     (wr_ok),
    .wr_idl_i    (reg_wdata_i[BIT_IDL]),
    .wr_pd_i     (reg_wdata_i[BIT_PD]),
    .wake_i      (wake),
    .vector_i    (vector),
    .vec_id_i    (eval_id),
    .run_o       (run),
    .pd_mode_o   (pd_mode),
    .clr_mode_o  (clr_mode),
    .cpu_clk_en_o(cpu_clk_en_o),
    .osc_en_o    (osc_en_o),
    .vec_req_o   (vec_req_o),
    .resume_o    (resume_o),
    .vec_id_o    (out_id)
  );

  assign vec_id_o    = 3'(out_id);
  assign reg_rdata_o = ctrl_q;

  p_sleep_write_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_clk_en_o && reg_we_i) |=> (reg_rdata_o == $past(reg_rdata_o)));
endmodule

// File: tb/test_pwr_wake_ctrl.sv
module test_pwr_wake_ctrl;
  localparam int unsigned STAB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] tflag = '0;
  logic       sflag = 1'b0, t2flag = 1'b0;
  logic [7:0] ie = '0;
  logic       clk_en, osc_en, vreq, resume;
  logic [2:0] vid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwr_wake_ctrl #(.STAB_CYC(STAB)) i_pwr_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .ext_int_ni(ext_n), .tmr_flag_i(tflag),
    .ser_flag_i(sflag), .tmr2_flag_i(t2flag), .irq_en_i(ie),
    .cpu_clk_en_o(clk_en), .osc_en_o(osc_en), .vec_req_o(vreq),
    .vec_id_o(vid), .resume_o(resume)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_src();
    ext_n = 2'b11; tflag = '0; sflag = 1'b0; t2flag = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 8'h00);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 pulses", {vreq, resume}, 0);
  endtask

  task automatic t_regs();
    wr(8'hDC);
    chk("R2 bit4 masked", reg_rdata, 8'hCC);
    chk("R2 still running", clk_en, 1);
    wr(8'h00);
    chk("R2 cleared", reg_rdata, 8'h00);
  endtask

  task automatic t_idle_vector();
    ie = 8'h82;
    wr(8'h0D);
    chk("R3 clk off", clk_en, 0);
    chk("R3 osc on", osc_en, 1);
    wr(8'hFF);
    chk("R2 write in sleep ignored", reg_rdata, 8'h0D);
    tflag = 2'b11;            // tmr1 not enabled, tmr0 enabled
    @(negedge clk);
    chk("R5 vec_req", vreq, 1);
    chk("R5 resume low", resume, 0);
    chk("R5 clk back", clk_en, 1);
    chk("R5 vec id", vid, 1);
    chk("R11 bits cleared", reg_rdata, 8'h0C);
    clear_src();
    @(negedge clk);
    chk("R5 single pulse", vreq, 0);
    chk("R5 running", clk_en, 1);
    ie = 8'h8C;
    wr(8'h01);
    ext_n = 2'b01; tflag = 2'b10;  // src2 and src3 pending
    @(negedge clk);
    chk("R5 priority id", vid, 2);
    chk("R9 ext1 low wakes", vreq, 1);
    clear_src();
    @(negedge clk);
  endtask

  task automatic t_idle_blocked();
    ie = 8'h7F;
    wr(8'h01);
    ext_n = 2'b00; tflag = 2'b11; sflag = 1'b1; t2flag = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 no global enable", {clk_en, vreq, resume}, 0);
    ie = 8'h80;
    repeat (3) @(negedge clk);
    chk("R6 no source enable", {clk_en, vreq, resume}, 0);
    ext_n = 2'b11; tflag = '0; t2flag = 1'b0;
    ie = 8'h90;
    @(negedge clk);
    chk("R8 serial wakes idle", vreq, 1);
    chk("R8 serial id", vid, 4);
    clear_src();
    @(negedge clk);
  endtask

  task automatic t_policy_resume();
    ie = 8'h00;
    wr(8'h21);
    chk("R3 idle entered", clk_en, 0);
    t2flag = 1'b1;
    @(negedge clk);
    chk("R7 resume", resume, 1);
    chk("R7 no vector", vreq, 0);
    chk("R7 id zero", vid, 0);
    chk("R7 clk back", clk_en, 1);
    chk("R11 policy kept", reg_rdata, 8'h20);
    clear_src();
    @(negedge clk);
    chk("R7 single pulse", resume, 0);
  endtask

  task automatic t_pdown();
    ie = 8'h00;
    wr(8'h23);
    chk("R4 pd priority osc", osc_en, 0);
    chk("R4 pd clk", clk_en, 0);
    sflag = 1'b1; t2flag = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 serial/t2 ignored in pd", {osc_en, clk_en, vreq, resume}, 0);
    clear_src();
    @(negedge clk);
    ext_n = 2'b10;
    @(negedge clk);
    chk("R10 osc restart", osc_en, 1);
    chk("R10 clk held", clk_en, 0);
    for (int i = 0; i < int'(STAB) - 1; i++) begin
      @(negedge clk);
      chk("R10 waiting", {clk_en, vreq, resume}, 0);
    end
    @(negedge clk);
    chk("R10 resume after settle", resume, 1);
    chk("R10 clk on", clk_en, 1);
    chk("R11 pd bits cleared", reg_rdata, 8'h20);
    clear_src();
    @(negedge clk);
    ie = 8'h88;
    wr(8'h02);
    tflag = 2'b10;
    @(negedge clk);
    chk("R10 osc restart vec", osc_en, 1);
    repeat (STAB - 1) @(negedge clk);
    chk("R10 no early pulse", vreq, 0);
    @(negedge clk);
    chk("R5 pd vector", vreq, 1);
    chk("R8 tmr1 id", vid, 3);
    clear_src();
    @(negedge clk);
  endtask

  task automatic t_reset_sleep();
    wr(8'h06);
    chk("R4 in pd", osc_en, 0);
    rst_n = 1'b0;
    #1;
    chk("R12 osc", osc_en, 1);
    chk("R12 clk", clk_en, 1);
    chk("R12 rdata", reg_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 running", {clk_en, osc_en}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_idle_vector();
    t_idle_blocked();
    t_policy_resume();
    t_pdown();
    t_reset_sleep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule